// File: doc/BRIEF.md
# Byte-Serial CRC-16 Engine with Byte Counter

This block is a register-mapped checksum accelerator. Software pushes frame
bytes into it one per bus write, and it keeps a running 16-bit frame check
value using the CCITT polynomial x^16+x^12+x^5+1. It processes the bits of
each byte least-significant first, starts from an all-ones remainder, and
complements the remainder on the way out. A 12-bit counter records how many
bytes have been folded in since the last clear.

The bus is a single request channel of 16-bit words with a one-cycle read
response. Each accepted request is a read or a write to one of four word
registers, selected by a 2-bit address:
- control (0): bit 15 is the clear command; bits [11:0] return the byte count.
- byte input (1): accepts the next byte.
- result (2): returns the finished check value.
- raw remainder (3): returns the uncomplemented remainder.

The channel's back-pressure rule is simple. `req_ready` is high in every
cycle, so a request is accepted in any cycle where `req_valid` is high. The
engine absorbs one byte per clock. Read responses are not back-pressured: the
requester must take `rsp_data` in the cycle where `rsp_valid` is high.

Top module: `crc16_engine`

## Requirements
- R1: After reset, a read of the control register returns 0x0000, the result register returns 0x0000 and the raw remainder register returns 0xFFFF.
- R2: A write to the control register (address 0) with bit 15 set returns the remainder to 0xFFFF and the byte count to 0, whatever the other bits hold.
- R3: A write to the control register with bit 15 clear changes neither the byte count nor the remainder.
- R4: A write to the byte input register (address 1) folds only bits [7:0] of the write data into the remainder; bits [15:8] have no effect on the result.
- R5: Each write to the byte input register raises the count by one; a control read carries the count in bits [11:0] and zeros in bits [15:12].
- R6: The count wraps from 4095 to 0 on the next byte write and keeps counting from there.
- R7: After a clear, the bytes 0xCC, 0xF5, 0xF1, 0xA7 written in that order give a count of 4 and a result of 0x51DF.
- R8: The result register (address 2) returns the remainder XOR 0xFFFF; the raw remainder register (address 3) returns it unchanged, which is 0xAE20 after the R7 sequence.
- R9: The response to a read accepted in cycle N appears with `rsp_valid` high in cycle N+1. A read issued in the cycle right after a byte write already sees that byte folded in. A read of the byte input register returns 0.
- R10: `req_ready` is always high, and an accepted write raises no `rsp_valid`.
- R11: Each byte is folded LSB-first with the reflected polynomial 0x8408: XOR the byte into the low 8 bits of the remainder, then, eight times, shift right and XOR 0x8408 when the bit shifted out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_ready | output | 1 | A request can be accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select: 0 control, 1 byte input, 2 result, 3 raw remainder |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_data | output | 16 | Read data |

## Verification
The hardest case to reach from the ports is the counter wrap. The count only
moves by one per byte write, so it takes 4095 consecutive writes to reach the
top value. The bench streams exactly that many bytes at one per clock and
reads the count at the top. It then writes two more bytes, checking for 0 and
then 1. The remainder arithmetic is also exercised with a long pseudo-random
byte stream. Each byte write is followed at once by a result read and compared
with a bitwise model, which also exercises the read-after-write timing.

// File: rtl/crc16_pkg.sv
`timescale 1ns/1ps
package crc16_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned CNT_W  = 12;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CLR_BIT = 15;

  localparam logic [CRC_W-1:0] POLY_REFL = 16'h8408;
  localparam logic [CRC_W-1:0] SEED      = 16'hFFFF;
  localparam logic [CRC_W-1:0] XOR_OUT   = 16'hFFFF;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_FEED = 2'd1,
    REG_SUM  = 2'd2,
    REG_RAW  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/crc16_byte_step.sv
`timescale 1ns/1ps
module crc16_byte_step #(
  parameter int unsigned CRC_W  = crc16_pkg::CRC_W,
  parameter int unsigned DATA_W = crc16_pkg::DATA_W,
  parameter logic [CRC_W-1:0] POLY = crc16_pkg::POLY_REFL
) (
  input  logic [CRC_W-1:0]  rem_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  rem_out
);
  localparam int unsigned PAD_W = CRC_W - DATA_W;

  logic [CRC_W-1:0] chain [0:DATA_W];

  assign chain[0] = rem_in ^ {{PAD_W{1'b0}}, data_in};

  // one reflected shift per data bit, LSB first
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign chain[i+1] = chain[i][0] ? ((chain[i] >> 1) ^ POLY) : (chain[i] >> 1);
  end

  assign rem_out = chain[DATA_W];
endmodule

// File: rtl/crc16_remainder.sv
`timescale 1ns/1ps
module crc16_remainder #(
  parameter int unsigned CRC_W  = crc16_pkg::CRC_W,
  parameter int unsigned DATA_W = crc16_pkg::DATA_W,
  parameter logic [CRC_W-1:0] POLY = crc16_pkg::POLY_REFL,
  parameter logic [CRC_W-1:0] SEED = crc16_pkg::SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  rem
);
  logic [CRC_W-1:0] rem_next;

  crc16_byte_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_step (
    .rem_in (rem),
    .data_in(data),
    .rem_out(rem_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rem <= SEED;
    else if (clr)  rem <= SEED;
    else if (load) rem <= rem_next;
  end

  a_r2_seed_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rem == SEED));
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> $stable(rem));
endmodule

// File: rtl/crc16_byte_count.sv
`timescale 1ns/1ps
module crc16_byte_count #(
  parameter int unsigned CNT_W = crc16_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  a_r2_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && (count != '1)) |=> (count == $past(count) + 1'b1));
  a_r6_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && (count == '1)) |=> (count == '0));
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(count));
endmodule

// File: rtl/crc16_engine.sv
`timescale 1ns/1ps
module crc16_engine
  import crc16_pkg::*;
#(
  parameter int unsigned BW = crc16_pkg::BUS_W,
  parameter int unsigned AW = crc16_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [BW-1:0] rsp_data
);
  localparam int unsigned CNT_PAD = BW - CNT_W;
  localparam int unsigned CRC_PAD = BW - CRC_W;

  reg_sel_e         sel;
  logic             fire;
  logic             do_clr;
  logic             do_feed;
  logic [CRC_W-1:0] rem;
  logic [CNT_W-1:0] count;
  logic [BW-1:0]    rd_word;
  logic             unused_wdata;

  assign req_ready    = 1'b1;
  assign fire         = req_valid && req_ready;
  assign sel          = reg_sel_e'(req_addr);
  assign do_clr       = fire && req_write && (sel == REG_CTRL) && req_wdata[CLR_BIT];
  assign do_feed      = fire && req_write && (sel == REG_FEED);
  assign unused_wdata = ^req_wdata[CLR_BIT-1:DATA_W];

  crc16_remainder #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY_REFL), .SEED(SEED)) u_rem (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (do_clr),
    .load (do_feed),
    .data (req_wdata[DATA_W-1:0]),
    .rem  (rem)
  );

  crc16_byte_count #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (do_clr),
    .inc  (do_feed),
    .count(count)
  );

  always_comb begin
    unique case (sel)
      REG_CTRL: rd_word = {{CNT_PAD{1'b0}}, count};
      REG_FEED: rd_word = '0;
      REG_SUM:  rd_word = {{CRC_PAD{1'b0}}, rem ^ XOR_OUT};
      REG_RAW:  rd_word = {{CRC_PAD{1'b0}}, rem};
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= fire && !req_write;
      if (fire && !req_write) rsp_data <= rd_word;
    end
  end

  a_r9_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r10_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  a_r10_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_ready);
  a_r5_count_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && !req_write && sel == REG_CTRL)) |-> (rsp_data[BW-1:CNT_W] == '0));
endmodule

// File: tb/crc16_engine_bench.sv
`timescale 1ns/1ps
module crc16_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [15:0] req_wdata = 16'h0000;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [15:0] model_rem;
  int unsigned model_cnt;

  always #2 clk = ~clk;

  crc16_engine u_crc16_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_fold(input logic [15:0] r, input logic [7:0] b);
    logic [15:0] x = r ^ {8'h00, b};
    for (int k = 0; k < 8; k++) x = x[0] ? ((x >> 1) ^ 16'h8408) : (x >> 1);
    return x;
  endfunction

  // tasks start just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check(rsp_valid == 1'b0, "R10 write raised rsp_valid", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
  endtask

  task automatic wr_fast(input logic [7:0] b);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 2'd1; req_wdata = {8'h5A, b};
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R9 rsp_valid after read", {31'd0, rsp_valid}, 32'd1);
    d = rsp_data;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check(req_ready == 1'b1, "R10 ready", {31'd0, req_ready}, 32'd1);
    rd(2'd0, v); check(v == 16'h0000, "R1 ctrl after reset", {16'd0, v}, 32'h0);
    rd(2'd2, v); check(v == 16'h0000, "R1 result after reset", {16'd0, v}, 32'h0);
    rd(2'd3, v); check(v == 16'hFFFF, "R1 raw after reset", {16'd0, v}, 32'hFFFF);
  endtask

  task automatic t_vector();
    logic [15:0] v;
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h00CC); wr(2'd1, 16'h00F5); wr(2'd1, 16'h00F1); wr(2'd1, 16'h00A7);
    rd(2'd0, v); check(v == 16'h0004, "R7 count after vector", {16'd0, v}, 32'h4);
    rd(2'd2, v); check(v == 16'h51DF, "R7 result after vector", {16'd0, v}, 32'h51DF);
    rd(2'd3, v); check(v == 16'hAE20, "R8 raw after vector", {16'd0, v}, 32'hAE20);
    rd(2'd1, v); check(v == 16'h0000, "R9 feed register reads zero", {16'd0, v}, 32'h0);
  endtask

  task automatic t_high_byte();
    logic [15:0] v;
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h12CC); wr(2'd1, 16'hABF5); wr(2'd1, 16'hFFF1); wr(2'd1, 16'h80A7);
    rd(2'd2, v); check(v == 16'h51DF, "R4 high byte ignored", {16'd0, v}, 32'h51DF);
  endtask

  task automatic t_no_clear();
    logic [15:0] v;
    wr(2'd0, 16'h7FFF);
    rd(2'd0, v); check(v == 16'h0004, "R3 count kept", {16'd0, v}, 32'h4);
    rd(2'd2, v); check(v == 16'h51DF, "R3 result kept", {16'd0, v}, 32'h51DF);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(2'd0, 16'h8000);
    rd(2'd0, v); check(v == 16'h0000, "R2 count cleared", {16'd0, v}, 32'h0);
    rd(2'd3, v); check(v == 16'hFFFF, "R2 remainder seeded", {16'd0, v}, 32'hFFFF);
  endtask

  task automatic t_model();
    logic [15:0] v;
    logic [7:0] lfsr = 8'hE1;
    wr(2'd0, 16'h8000);
    model_rem = 16'hFFFF; model_cnt = 0;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr(2'd1, {~lfsr, lfsr});
      model_rem = ref_fold(model_rem, lfsr);
      model_cnt++;
      rd(2'd2, v);
      check(v == (model_rem ^ 16'hFFFF), "R11 fold vs model (R9 read after write)", {16'd0, v}, {16'd0, model_rem ^ 16'hFFFF});
    end
    rd(2'd0, v); check(v == model_cnt[15:0], "R5 count after stream", {16'd0, v}, model_cnt);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wr(2'd0, 16'h8000);
    for (int n = 0; n < 4095; n++) wr_fast(n[7:0]);
    rd(2'd0, v); check(v == 16'h0FFF, "R6 count at top (R5 high bits zero)", {16'd0, v}, 32'hFFF);
    wr(2'd1, 16'h0001);
    rd(2'd0, v); check(v == 16'h0000, "R6 count wrapped", {16'd0, v}, 32'h0);
    wr(2'd1, 16'h0002);
    rd(2'd0, v); check(v == 16'h0001, "R6 count after wrap", {16'd0, v}, 32'h1);
  endtask

  initial begin
    #200_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vector();
    t_no_clear();
    t_clear();
    t_high_byte();
    t_model();
    t_wrap();
    t_vector();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule